// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block is a small 2D drawing engine. Software feeds it 32-bit command words through a write-only command queue. It draws into a linear pixel store through a synchronous memory port. It runs two operations. A solid fill paints every pixel of a rectangle with the foreground colour. A copy moves a rectangle from one place to another, and the copy's scan direction is picked by two command bits, so that a copy between overlapping rectangles comes out as if the source had been read in full first.

Every pixel sits at address `base + y*stride + x`, truncated to the memory address width. Writes that fall outside an inclusive clipping window are dropped. Software polls a free-slot count before it writes a packet, and polls busy bits to learn when drawing is done. A soft reset recovers the engine from a hang.

Register offsets on the 4-bit register address:

| Offset | Use |
|---|---|
| 0 | command queue (write-only) |
| 1 | status |
| 2 | free slots |
| 3 | foreground colour |
| 4 | background colour |
| 5 | base |
| 6 | stride |
| 7 | clip x min |
| 8 | clip x max |
| 9 | clip y min |
| 10 | clip y max |
| 11 | mode |
| 12 | soft reset |

Top module: `rect_blit_engine`

## Requirements
- R1: A fill packet is three queue words: exactly 0x09410000, then Y in bits 31:16 and X in bits 15:0, then height in bits 31:16 and width in bits 15:0. Every pixel of the rectangle receives the foreground colour. A zero width or a zero height writes nothing.
- R2: A copy packet is four words: an opcode with bits 31:18 equal to those of 0x0D440000 and bits 15:0 zero, then the source position, then the destination position, then the size. Bit 16 set scans X from the far edge down, and bit 17 set does the same for Y. When the direction is chosen from the relative positions, an overlapping copy equals a copy from a snapshot of the source.
- R3: Pixel (x,y) is stored at address base + y*stride + x, modulo the memory size.
- R4: Writes are suppressed unless clip x min <= x <= clip x max and clip y min <= y <= clip y max.
- R5: Mode bit 15 set (0x8000) selects 16-bit pixels, in which all 16 data bits are written. With the bit clear, only the low 8 bits are kept and the upper byte is written as zero, for both fill and copy.
- R6: The free-slot register reads the queue depth (16) minus the number of queued words.
- R7: A queue write while the queue is full is ignored, and it sets sticky status bit 13.
- R8: A first packet word that is neither opcode is dropped and sets sticky status bit 12. The next word is then decoded as a fresh opcode.
- R9: Status bit 0 (engine or queue busy), bit 4 (fill), bit 5 (copy) and bit 8 (queue not empty) are all zero once every queued command has finished. At least one of them is set while work is pending.
- R10: Writing 1 to bit 0 of the soft-reset register aborts the operation in progress and empties the queue. The next cycle shows status 0, including both sticky flags, and a free count of 16. Later packets then run normally.
- R11: After reset the status reads 0 and the free count reads 16. The clip window is 0..XRES by 0..YRES, the mode reads 0x8000 and the stride reads XRES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 4 | register offset |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data, combinational on reg_addr |
| mem_we | output | 1 | pixel write enable |
| mem_re | output | 1 | pixel read enable, data returned one cycle later |
| mem_addr | output | AW | pixel address |
| mem_wdata | output | 16 | pixel write data |
| mem_rdata | input | 16 | pixel read data |

## Verification
A corrupted scan counter or position register shows up as pixels in the wrong place. The bench compares the whole pixel store after each command, so such an error is caught at the end of that command. A wrong direction latch can be seen only in an overlapping copy, and only in its overlap region, so directed overlapping copies in all four directions are mixed in with random ones. A bad queue count shows up at once in the free-slot register, and any later packet then decodes as garbage. That garbage sets the error flag and leaves the busy bits stuck, which the idle wait exposes.

// File: rtl/rbe_pkg.sv
package rbe_pkg;
  localparam logic [31:0] OP_FILL    = 32'h0941_0000;
  localparam logic [13:0] OP_COPY_HI = 14'h0351;   // bits 31:18 of 0x0D44xxxx

  localparam logic [3:0] RA_QUEUE = 4'd0;
  localparam logic [3:0] RA_STAT  = 4'd1;
  localparam logic [3:0] RA_FREE  = 4'd2;
  localparam logic [3:0] RA_FG    = 4'd3;
  localparam logic [3:0] RA_BG    = 4'd4;
  localparam logic [3:0] RA_BASE  = 4'd5;
  localparam logic [3:0] RA_LW    = 4'd6;
  localparam logic [3:0] RA_CXMIN = 4'd7;
  localparam logic [3:0] RA_CXMAX = 4'd8;
  localparam logic [3:0] RA_CYMIN = 4'd9;
  localparam logic [3:0] RA_CYMAX = 4'd10;
  localparam logic [3:0] RA_MODE  = 4'd11;
  localparam logic [3:0] RA_SRST  = 4'd12;

  typedef enum logic [2:0] {
    S_OP, S_W1, S_W2, S_W3, S_FILL, S_CRD, S_CWR
  } eng_st_e;

  function automatic logic is_fill(logic [31:0] w);
    return w == OP_FILL;
  endfunction

  function automatic logic is_copy(logic [31:0] w);
    return (w[31:18] == OP_COPY_HI) && (w[15:0] == 16'h0000);
  endfunction

  // position along one axis: from the near edge upward or the far edge downward
  function automatic logic [15:0] scan_pos(logic [15:0] org, logic [15:0] len,
                                           logic [15:0] cnt, logic dec);
    return dec ? (org + len - 16'd1 - cnt) : (org + cnt);
  endfunction

  function automatic logic in_win(logic [15:0] x, logic [15:0] y,
                                  logic [15:0] xlo, logic [15:0] xhi,
                                  logic [15:0] ylo, logic [15:0] yhi);
    return (x >= xlo) && (x <= xhi) && (y >= ylo) && (y <= yhi);
  endfunction
endpackage

// File: rtl/rbe_cmd_fifo.sv
module rbe_cmd_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] free,
  output logic          ovf_evt
);
  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign ovf_evt = push && full && !flush;
  assign rdata   = slot_q[rp_q];
  assign free    = CW'(DEPTH) - cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + PW'(1);
      if (do_pop)  rp_q <= rp_q + PW'(1);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wp_q] <= wdata;
  end
endmodule

// File: rtl/rbe_exec.sv
module rbe_exec import rbe_pkg::*; #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          cmd_empty,
  input  logic [31:0]   cmd_word,
  output logic          cmd_pop,
  input  logic [15:0]   fg,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  input  logic [15:0]   cxmin,
  input  logic [15:0]   cxmax,
  input  logic [15:0]   cymin,
  input  logic [15:0]   cymax,
  input  logic          mode16,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          busy,
  output logic          fill_act,
  output logic          copy_act,
  output logic          err_evt,
  output logic [15:0]   wr_x,
  output logic [15:0]   wr_y
);
  function automatic logic [AW-1:0] lin_addr(logic [AW-1:0] b, logic [AW-1:0] s,
                                             logic [15:0] x, logic [15:0] y);
    return b + AW'(y) * s + AW'(x);
  endfunction

  eng_st_e     st_q;
  logic        cpy_q, xdec_q, ydec_q;
  logic [31:0] p0_q, p1_q, sz_q, dst_w;
  logic [15:0] cx_q, cy_q, w, h, src_x, src_y, pix;
  logic        last_x, last_px, sz_zero, take, step;

  assign w       = sz_q[15:0];
  assign h       = sz_q[31:16];
  assign last_x  = (cx_q == w - 16'd1);
  assign last_px = last_x && (cy_q == h - 16'd1);
  assign sz_zero = (cmd_word[31:16] == '0) || (cmd_word[15:0] == '0);
  assign take    = (st_q inside {S_OP, S_W1, S_W2, S_W3}) && !cmd_empty;
  assign step    = (st_q == S_FILL) || (st_q == S_CWR);
  assign cmd_pop = take;
  assign err_evt = (st_q == S_OP) && !cmd_empty && !is_fill(cmd_word) && !is_copy(cmd_word);

  assign dst_w = cpy_q ? p1_q : p0_q;
  assign src_x = scan_pos(p0_q[15:0],   w, cx_q, xdec_q);
  assign src_y = scan_pos(p0_q[31:16],  h, cy_q, ydec_q);
  assign wr_x  = scan_pos(dst_w[15:0],  w, cx_q, xdec_q);
  assign wr_y  = scan_pos(dst_w[31:16], h, cy_q, ydec_q);

  assign mem_re    = (st_q == S_CRD);
  assign mem_addr  = mem_re ? lin_addr(base, stride, src_x, src_y)
                            : lin_addr(base, stride, wr_x, wr_y);
  assign pix       = (st_q == S_FILL) ? fg : mem_rdata;
  assign mem_wdata = mode16 ? pix : {8'h00, pix[7:0]};
  assign mem_we    = step && in_win(wr_x, wr_y, cxmin, cxmax, cymin, cymax);

  assign busy     = (st_q != S_OP);
  assign fill_act = busy && !cpy_q;
  assign copy_act = busy && cpy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_OP;  cpy_q <= 1'b0;  xdec_q <= 1'b0;  ydec_q <= 1'b0;
      p0_q <= '0;    p1_q <= '0;     sz_q <= '0;      cx_q <= '0;  cy_q <= '0;
    end else if (flush) begin
      st_q <= S_OP;
    end else begin
      case (st_q)
        S_OP: if (take) begin
          if (is_fill(cmd_word)) begin
            cpy_q <= 1'b0;  xdec_q <= 1'b0;  ydec_q <= 1'b0;  st_q <= S_W1;
          end else if (is_copy(cmd_word)) begin
            cpy_q <= 1'b1;  xdec_q <= cmd_word[16];  ydec_q <= cmd_word[17];  st_q <= S_W1;
          end
        end
        S_W1: if (take) begin
          p0_q <= cmd_word;
          st_q <= S_W2;
        end
        S_W2: if (take) begin
          if (cpy_q) begin
            p1_q <= cmd_word;
            st_q <= S_W3;
          end else begin
            sz_q <= cmd_word;  cx_q <= '0;  cy_q <= '0;
            st_q <= sz_zero ? S_OP : S_FILL;
          end
        end
        S_W3: if (take) begin
          sz_q <= cmd_word;  cx_q <= '0;  cy_q <= '0;
          st_q <= sz_zero ? S_OP : S_CRD;
        end
        S_CRD: st_q <= S_CWR;
        default: begin
          if (last_x) begin
            cx_q <= '0;
            cy_q <= cy_q + 16'd1;
          end else begin
            cx_q <= cx_q + 16'd1;
          end
          if (last_px)             st_q <= S_OP;
          else if (st_q == S_CWR)  st_q <= S_CRD;
        end
      endcase
    end
  end
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine import rbe_pkg::*; #(
  parameter int AW         = 12,
  parameter int FIFO_DEPTH = 16,
  parameter int XRES       = 64,
  parameter int YRES       = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [15:0]   fg_q, bg_q, cxmin_q, cxmax_q, cymin_q, cymax_q;
  logic [AW-1:0] base_q, lw_q;
  logic          mode16_q, err_flag, ovf_flag;
  logic          srst, push_req, fifo_empty, fifo_full, fifo_pop, ovf_evt;
  logic          exec_busy, fill_act, copy_act, err_evt, busy_any;
  logic [31:0]   head_word, stat_word;
  logic [CW-1:0] free_cnt;
  logic [15:0]   wr_x, wr_y;

  assign srst     = reg_wr && (reg_addr == RA_SRST) && reg_wdata[0];
  assign push_req = reg_wr && (reg_addr == RA_QUEUE);
  assign busy_any = exec_busy || !fifo_empty;
  assign stat_word = {18'b0, ovf_flag, err_flag, 3'b0, !fifo_empty, 2'b0,
                      copy_act, fill_act, 3'b0, busy_any};

  rbe_cmd_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(srst), .push(push_req), .wdata(reg_wdata),
    .pop(fifo_pop), .rdata(head_word), .empty(fifo_empty), .full(fifo_full),
    .free(free_cnt), .ovf_evt(ovf_evt)
  );

  rbe_exec #(.AW(AW)) exec_i (
    .clk(clk), .rst_n(rst_n), .flush(srst), .cmd_empty(fifo_empty),
    .cmd_word(head_word), .cmd_pop(fifo_pop), .fg(fg_q), .base(base_q),
    .stride(lw_q), .cxmin(cxmin_q), .cxmax(cxmax_q), .cymin(cymin_q),
    .cymax(cymax_q), .mode16(mode16_q), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(exec_busy), .fill_act(fill_act), .copy_act(copy_act),
    .err_evt(err_evt), .wr_x(wr_x), .wr_y(wr_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fg_q <= '0;  bg_q <= '0;  base_q <= '0;  lw_q <= AW'(XRES);
      cxmin_q <= '0;  cxmax_q <= 16'(XRES);  cymin_q <= '0;  cymax_q <= 16'(YRES);
      mode16_q <= 1'b1;  err_flag <= 1'b0;  ovf_flag <= 1'b0;
    end else begin
      if (srst) begin
        err_flag <= 1'b0;
        ovf_flag <= 1'b0;
      end else begin
        err_flag <= err_flag || err_evt;
        ovf_flag <= ovf_flag || ovf_evt;
      end
      if (reg_wr) begin
        case (reg_addr)
          RA_FG:    fg_q     <= reg_wdata[15:0];
          RA_BG:    bg_q     <= reg_wdata[15:0];
          RA_BASE:  base_q   <= reg_wdata[AW-1:0];
          RA_LW:    lw_q     <= reg_wdata[AW-1:0];
          RA_CXMIN: cxmin_q  <= reg_wdata[15:0];
          RA_CXMAX: cxmax_q  <= reg_wdata[15:0];
          RA_CYMIN: cymin_q  <= reg_wdata[15:0];
          RA_CYMAX: cymax_q  <= reg_wdata[15:0];
          RA_MODE:  mode16_q <= reg_wdata[15];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_STAT:  reg_rdata = stat_word;
      RA_FREE:  reg_rdata = 32'(free_cnt);
      RA_FG:    reg_rdata = {16'b0, fg_q};
      RA_BG:    reg_rdata = {16'b0, bg_q};
      RA_BASE:  reg_rdata = 32'(base_q);
      RA_LW:    reg_rdata = 32'(lw_q);
      RA_CXMIN: reg_rdata = {16'b0, cxmin_q};
      RA_CXMAX: reg_rdata = {16'b0, cxmax_q};
      RA_CYMIN: reg_rdata = {16'b0, cymin_q};
      RA_CYMAX: reg_rdata = {16'b0, cymax_q};
      RA_MODE:  reg_rdata = {16'b0, mode16_q, 15'b0};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rbe_checker.sv
module rbe_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          srst,
  input logic          ovf_evt,
  input logic          ovf_flag,
  input logic          err_evt,
  input logic          err_flag,
  input logic          mem_we,
  input logic          busy_any,
  input logic [CW-1:0] free_cnt,
  input logic [15:0]   wr_x,
  input logic [15:0]   wr_y,
  input logic [15:0]   cxmin,
  input logic [15:0]   cxmax,
  input logic [15:0]   cymin,
  input logic [15:0]   cymax
);
  a_r4_clip_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wr_x >= cxmin && wr_x <= cxmax && wr_y >= cymin && wr_y <= cymax));

  a_r6_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CW'(DEPTH));

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !srst) |=> ovf_flag);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !srst) |=> err_flag);

  a_r9_write_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy_any);

  a_r10_soft_reset_flush: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (free_cnt == CW'(DEPTH) && !busy_any && !err_flag && !ovf_flag));
endmodule

bind rect_blit_engine rbe_checker #(.DEPTH(FIFO_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .srst(srst), .ovf_evt(ovf_evt), .ovf_flag(ovf_flag),
  .err_evt(err_evt), .err_flag(err_flag), .mem_we(mem_we), .busy_any(busy_any),
  .free_cnt(free_cnt), .wr_x(wr_x), .wr_y(wr_y), .cxmin(cxmin_q),
  .cxmax(cxmax_q), .cymin(cymin_q), .cymax(cymax_q)
);

// File: tb/rect_blit_engine_tb_top.sv
`timescale 1ns/1ps
module rect_blit_engine_tb_top;
  localparam int AW = 12, MEMN = 1 << AW, XRES = 64, YRES = 48;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_we, mem_re;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = '0;

  logic [15:0] pmem [MEMN];
  logic [15:0] expm [MEMN];
  logic [15:0] snap [MEMN];

  int checks = 0, failures = 0;
  int m_base = 0, m_lw = XRES, m_xlo = 0, m_xhi = XRES, m_ylo = 0, m_yhi = YRES;
  bit m_m16 = 1'b1;
  logic [15:0] m_fg = '0;

  always #2.5 clk = ~clk;

  rect_blit_engine #(.AW(AW), .FIFO_DEPTH(16), .XRES(XRES), .YRES(YRES)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) pmem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= pmem[mem_addr];
  end

  task automatic check(input string req, input int got, input int exp_v);
    checks++;
    if (got != exp_v) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp_v);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  function automatic int baddr(int x, int y);
    return (m_base + y * m_lw + x) % MEMN;
  endfunction

  function automatic bit inclip(int x, int y);
    return x >= m_xlo && x <= m_xhi && y >= m_ylo && y <= m_yhi;
  endfunction

  function automatic logic [15:0] depth_mask(logic [15:0] v);
    return m_m16 ? v : {8'h00, v[7:0]};
  endfunction

  function automatic void model_fill(int x, int y, int w, int h);
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++)
        if (inclip(x + i, y + j)) expm[baddr(x + i, y + j)] = depth_mask(m_fg);
  endfunction

  function automatic void model_copy(int sx, int sy, int dx, int dy, int w, int h);
    for (int k = 0; k < MEMN; k++) snap[k] = expm[k];
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++)
        if (inclip(dx + i, dy + j))
          expm[baddr(dx + i, dy + j)] = depth_mask(snap[baddr(sx + i, sy + j)]);
  endfunction

  task automatic wait_idle(input string req);
    int st = 0;
    for (int n = 0; n < 20000; n++) begin
      rd(4'd1, st);
      if ((st & 32'h131) == 0) break;
    end
    check(req, st & 32'h131, 0);
  endtask

  task automatic check_mem(input string req);
    int bad = 0, first = -1;
    for (int k = 0; k < MEMN; k++)
      if (pmem[k] !== expm[k]) begin
        bad++;
        if (first < 0) first = k;
      end
    if (first >= 0) $display("  mismatch at 0x%0h: actual=0x%0h expected=0x%0h",
                             first, pmem[first], expm[first]);
    check(req, bad, 0);
  endtask

  task automatic do_fill(input string req, input int x, input int y, input int w, input int h);
    model_fill(x, y, w, h);
    wr(4'd0, 32'h0941_0000);
    wr(4'd0, {16'(y), 16'(x)});
    wr(4'd0, {16'(h), 16'(w)});
    wait_idle(req);
    check_mem(req);
  endtask

  task automatic do_copy(input string req, input int sx, input int sy, input int dx,
                         input int dy, input int w, input int h);
    logic [31:0] op;
    op = 32'h0D44_0000;
    if (sx < dx) op[16] = 1'b1;
    if (sy < dy) op[17] = 1'b1;
    model_copy(sx, sy, dx, dy, w, h);
    wr(4'd0, op);
    wr(4'd0, {16'(sy), 16'(sx)});
    wr(4'd0, {16'(dy), 16'(dx)});
    wr(4'd0, {16'(h), 16'(w)});
    wait_idle(req);
    check_mem(req);
  endtask

  task automatic set_fg(input logic [15:0] c);
    m_fg = c;
    wr(4'd3, {16'b0, c});
  endtask

  initial begin
    #(200000 * 5);
    failures++; checks++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < MEMN; k++) begin
      pmem[k] = 16'($urandom);
      expm[k] = pmem[k];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(4'd1, v);  check("R11 status after reset", v, 0);
    rd(4'd2, v);  check("R11 free after reset", v, 16);
    rd(4'd8, v);  check("R11 clip xmax", v, XRES);
    rd(4'd10, v); check("R11 clip ymax", v, YRES);
    rd(4'd11, v); check("R11 mode", v, 32'h8000);
    rd(4'd6, v);  check("R11 stride", v, XRES);

    // R1 directed fill, R9 busy visible right after the packet
    set_fg(16'hBEEF);
    model_fill(3, 2, 5, 4);
    wr(4'd0, 32'h0941_0000);
    wr(4'd0, {16'd2, 16'd3});
    wr(4'd0, {16'd4, 16'd5});
    rd(4'd1, v);  check("R9 busy while pending", int'((v & 32'h131) != 0), 1);
    wait_idle("R9 idle after fill");
    check_mem("R1 directed fill");
    do_fill("R1 zero width", 7, 7, 0, 5);
    do_fill("R1 zero height", 7, 7, 5, 0);

    // R6 free count with a queued partial packet
    wr(4'd0, 32'h0941_0000);
    wr(4'd0, 32'h0);
    rd(4'd2, v);  check("R6 free after partial packet drained", v, 16);
    set_fg(16'h1234);
    do_fill("R6 completing packet", 1, 1, 0, 0);  // size word with zero size
    rd(4'd1, v);  check("R6 no stray pending", v & 32'h131, 0);

    // R3 base and stride
    m_base = 100; m_lw = 40;
    wr(4'd5, 100); wr(4'd6, 40);
    do_fill("R3 base stride fill", 4, 6, 9, 3);
    m_base = 0; m_lw = XRES;
    wr(4'd5, 0); wr(4'd6, XRES);

    // R4 clip window
    m_xlo = 10; m_xhi = 20; m_ylo = 5; m_yhi = 8;
    wr(4'd7, 10); wr(4'd8, 20); wr(4'd9, 5); wr(4'd10, 8);
    set_fg(16'h0F0F);
    do_fill("R4 clipped fill", 0, 0, 40, 20);
    do_copy("R4 clipped copy", 30, 20, 5, 3, 25, 10);
    m_xlo = 0; m_xhi = XRES; m_ylo = 0; m_yhi = YRES;
    wr(4'd7, 0); wr(4'd8, XRES); wr(4'd9, 0); wr(4'd10, YRES);

    // R5 8-bit pixels
    m_m16 = 1'b0; wr(4'd11, 0);
    set_fg(16'hABCD);
    do_fill("R5 8bpp fill", 2, 30, 6, 3);
    do_copy("R5 8bpp copy", 40, 10, 44, 30, 8, 4);
    m_m16 = 1'b1; wr(4'd11, 32'h8000);
    set_fg(16'hABCD);
    do_fill("R5 16bpp fill", 2, 40, 6, 3);

    // R2 overlapping copies in all four directions
    do_copy("R2 copy both decrement", 10, 10, 12, 11, 9, 7);
    do_copy("R2 copy both increment", 12, 11, 10, 10, 9, 7);
    do_copy("R2 copy x decrement", 10, 11, 13, 10, 9, 7);
    do_copy("R2 copy y decrement", 13, 10, 10, 12, 9, 7);

    // R1 R2 random mix
    for (int it = 0; it < 24; it++) begin
      int w, h, sx, sy, dx, dy;
      w = 1 + int'($urandom % 16); h = 1 + int'($urandom % 12);
      sx = int'($urandom % (XRES - w + 1)); sy = int'($urandom % (YRES - h + 1));
      if (it % 2 == 0) begin
        set_fg(16'($urandom));
        do_fill("R1 random fill", sx, sy, w, h);
      end else begin
        dx = sx + int'($urandom % 9) - 4; dy = sy + int'($urandom % 9) - 4;
        if (dx < 0) dx = 0;
        if (dy < 0) dy = 0;
        if (dx > XRES - w) dx = XRES - w;
        if (dy > YRES - h) dy = YRES - h;
        do_copy("R2 random copy", sx, sy, dx, dy, w, h);
      end
    end

    // R8 unknown opcode then a good packet
    wr(4'd0, 32'h1234_5678);
    set_fg(16'h5A5A);
    do_fill("R8 fill after bad opcode", 20, 20, 4, 4);
    rd(4'd1, v);  check("R8 error flag bit 12", (v >> 12) & 1, 1);

    // R7 overflow while a long fill runs
    set_fg(16'h7777);
    model_fill(0, 0, 64, 16);
    wr(4'd0, 32'h0941_0000); wr(4'd0, 32'h0); wr(4'd0, {16'd16, 16'd64});
    for (int p = 0; p < 4; p++) begin
      wr(4'd0, 32'h0D44_0000); wr(4'd0, 32'h0); wr(4'd0, 32'h0); wr(4'd0, 32'h0);
    end
    rd(4'd2, v);  check("R7 free is zero when full", v, 0);
    wr(4'd0, 32'h0941_0000);
    rd(4'd1, v);  check("R7 overflow flag bit 13", (v >> 13) & 1, 1);
    rd(4'd2, v);  check("R7 dropped word not queued", v, 0);
    wait_idle("R7 idle, extra word ignored");
    rd(4'd2, v);  check("R7 free restored", v, 16);
    check_mem("R7 long fill intact");

    // R10 soft reset mid operation
    set_fg(16'h3C3C);
    wr(4'd0, 32'h0941_0000); wr(4'd0, 32'h0); wr(4'd0, {16'd40, 16'd48});
    wr(4'd0, 32'h0941_0000);
    repeat (20) @(negedge clk);
    wr(4'd12, 32'h1);
    rd(4'd1, v);  check("R10 status cleared", v, 0);
    rd(4'd2, v);  check("R10 queue emptied", v, 16);
    repeat (5) @(negedge clk);
    rd(4'd1, v);  check("R10 engine stays idle", v, 0);
    for (int k = 0; k < MEMN; k++) expm[k] = pmem[k];
    set_fg(16'hC3C3);
    do_fill("R10 fill after soft reset", 30, 30, 5, 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule